// File: doc/BRIEF.md
# Speculative Router Input Channel Controller

This block steers one input channel of a wormhole router on a 2-D mesh. The channel keeps a guess of which output the next packet will take. While the channel is empty it asks the switch arbiter for a low-priority, tentative hold on that guessed output. When a head flit reaches the front of the input queue and the hold is granted, the flit crosses the switch in that same cycle. Dimension-ordered route computation runs alongside it. A correct guess means each flit spends one cycle in the router.

A wrong guess is repaired. The controller pulses a kill toward the output that received the flit, so that the downstream side discards it as dead. It then requests the correct output at full priority and sends the head again from the queue, which it never released. The repaired packet therefore leaves on the third cycle, the same as a conventional route, allocate and traverse pipeline. A head that arrives with no granted hold follows that conventional pipeline without any kill. The tail flit returns the channel to idle, where a new tentative hold is requested.

The queue, the crossbar, the predictor and the arbiter are outside the block. It sees the front of the queue, the guessed port, a request/grant pair toward the arbiter, and it drives a one-hot forward strobe, a one-hot kill and the computed route.

Top module: `spec_input_channel`

## Requirements
- R1: After reset the channel is idle. With no flit waiting, it drives no forward strobe, no kill and no pop, and it makes a tentative request (`resv_firm` = 0) on the predicted port.
- R2: Ports are numbered 0 local, 1 X+, 2 X-, 3 Y+, 4 Y-. Every one-hot vector has bit i for port i. While idle and empty, the request is the one-hot of `pred_port` with `resv_firm` low. A grant in that state reserves that port.
- R3: The route is computed in dimension order from the head flit. The destination X is held in bits [3:0] and the destination Y in bits [7:4]. The route is X+ if dest X > `my_x`, X- if dest X < `my_x`, otherwise Y+ if dest Y > `my_y`, Y- if dest Y < `my_y`, else local. `route_valid` is high in the cycle the route is computed.
- R4: Flit type is held in bits [15:14]: 00 body, 01 head, 10 tail, 11 head-and-tail. In the reserved state, a head arriving while the grant is high is strobed to the reserved port in the same cycle. If the route equals that port, the head is popped in that cycle and no kill follows.
- R5: After a hit, each later flit of the packet is strobed to the same port and popped in the cycle it is presented.
- R6: On a miss, the head is strobed to the reserved port without a pop. In the next cycle `kill` is the one-hot of the wrongly used port for exactly one cycle. In that same cycle a firm request (`resv_firm` = 1) is made on the computed route.
- R7: After a miss, if the firm grant is high in the cycle after the speculative send, the head is strobed to the correct port and popped in the third cycle.
- R8: A head that finds no granted reservation takes the conventional path: no strobe in the route cycle, a firm request next, and a send with pop in the cycle after the grant. No kill is raised at any point.
- R9: In the reserved state with no flit, the request stays on the reserved port even if the prediction changes. A cycle without grant returns the channel to idle, where it requests the current prediction.
- R10: Popping a tail or head-and-tail flit returns the channel to idle, where the tentative request on the prediction resumes.
- R11: While a firm request waits for its grant, nothing is strobed, popped or killed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | 4 | X coordinate of this router |
| my_y | input | 4 | Y coordinate of this router |
| in_flit | input | 16 | Flit at the front of the input queue |
| in_valid | input | 1 | Queue front holds a flit |
| in_ready | output | 1 | Pop the queue front this cycle |
| pred_port | input | 3 | Predicted output port |
| resv_req | output | 5 | One-hot output port requested from the arbiter |
| resv_firm | output | 1 | 1: full-priority request, 0: tentative hold |
| resv_gnt | input | 1 | Arbiter grants the requested port |
| out_flit | output | 16 | Flit presented to the crossbar |
| out_valid | output | 5 | One-hot output strobe for `out_flit` |
| kill | output | 5 | One-hot kill toward a wrongly used output |
| route_valid | output | 1 | Route computed this cycle |
| route_port | output | 3 | Computed output port |

## Verification
The bench drives four packet patterns and compares their cycle timing and strobes. A correctly guessed multi-flit packet must show one-cycle flow with no kill. A wrongly guessed packet, run both with an immediate grant and with a grant delayed two cycles, must show the single kill pulse, the firm request and the resend. A single-flit head with no reservation must stay kill-free. One stream is routed to each of the five directions so that dimension order is told apart from Y-first routing. A reservation the arbiter withdraws must show that the held port and the live prediction are tracked separately.

// File: rtl/spec_pkg.sv
`timescale 1ns/1ps
package spec_pkg;
  localparam int NPORT  = 5;
  localparam int PORT_W = 3;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XM    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YM    = 3'd4
  } port_e;

  typedef enum logic [2:0] {
    ST_IDLE,    // empty, tentative request on the guess
    ST_RESV,    // guessed port held
    ST_ALLOC,   // firm request on the computed route
    ST_SEND,    // head leaves the queue
    ST_ACTIVE   // packet body streams through
  } chan_st_e;
endpackage

// File: rtl/spec_xy_route.sv
`timescale 1ns/1ps
module spec_xy_route #(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0]        here_x,
  input  logic [COORD_W-1:0]        here_y,
  input  logic [COORD_W-1:0]        dest_x,
  input  logic [COORD_W-1:0]        dest_y,
  output logic [spec_pkg::PORT_W-1:0] port
);
  import spec_pkg::*;

  always_comb begin
    if (dest_x > here_x)      port = PORT_XP;
    else if (dest_x < here_x) port = PORT_XM;
    else if (dest_y > here_y) port = PORT_YP;
    else if (dest_y < here_y) port = PORT_YM;
    else                      port = PORT_LOCAL;
  end
endmodule

// File: rtl/spec_port_dec.sv
`timescale 1ns/1ps
module spec_port_dec #(
  parameter int NP = 5,
  parameter int PW = 3
) (
  input  logic [PW-1:0] idx,
  input  logic          en,
  output logic [NP-1:0] vec
);
  for (genvar g = 0; g < NP; g++) begin : g_bit
    assign vec[g] = en && (idx == PW'(g));
  end
endmodule

// File: rtl/spec_input_channel.sv
`timescale 1ns/1ps
module spec_input_channel #(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 4,
  localparam int NP = spec_pkg::NPORT,
  localparam int PW = spec_pkg::PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COORD_W-1:0] my_x,
  input  logic [COORD_W-1:0] my_y,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PW-1:0]     pred_port,
  output logic [NP-1:0]     resv_req,
  output logic              resv_firm,
  input  logic              resv_gnt,
  output logic [FLIT_W-1:0] out_flit,
  output logic [NP-1:0]     out_valid,
  output logic [NP-1:0]     kill,
  output logic              route_valid,
  output logic [PW-1:0]     route_port
);
  import spec_pkg::*;

  chan_st_e      st_q, st_d;
  logic [PW-1:0] cur_q, cur_d;
  logic [NP-1:0] kill_q, kill_d;

  logic [1:0]    ftype;
  logic          is_head, is_tail, pred_ok, hit;
  logic [PW-1:0] rc_port, req_idx, out_idx;
  logic          req_en, out_en;
  logic [NP-1:0] cur_vec;

  assign ftype   = in_flit[FLIT_W-1 -: 2];
  assign is_head = in_valid && ftype[0];
  assign is_tail = in_valid && ftype[1];
  assign pred_ok = (pred_port < PW'(NP));
  assign hit     = (rc_port == cur_q);

  spec_xy_route #(.COORD_W(COORD_W)) u_route (
    .here_x (my_x),
    .here_y (my_y),
    .dest_x (in_flit[COORD_W-1:0]),
    .dest_y (in_flit[2*COORD_W-1:COORD_W]),
    .port   (rc_port)
  );

  spec_port_dec #(.NP(NP), .PW(PW)) u_req_dec (
    .idx (req_idx), .en (req_en), .vec (resv_req)
  );
  spec_port_dec #(.NP(NP), .PW(PW)) u_out_dec (
    .idx (out_idx), .en (out_en), .vec (out_valid)
  );
  spec_port_dec #(.NP(NP), .PW(PW)) u_cur_dec (
    .idx (cur_q), .en (1'b1), .vec (cur_vec)
  );

  // next-state and output decode
  always_comb begin
    st_d        = st_q;
    cur_d       = cur_q;
    kill_d      = '0;
    in_ready    = 1'b0;
    out_en      = 1'b0;
    out_idx     = cur_q;
    req_en      = 1'b0;
    req_idx     = cur_q;
    resv_firm   = 1'b0;
    route_valid = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (is_head) begin
          // no hold yet: conventional route stage
          route_valid = 1'b1;
          cur_d       = rc_port;
          st_d        = ST_ALLOC;
        end else if (!in_valid) begin
          req_en  = pred_ok;
          req_idx = pred_port;
          if (pred_ok && resv_gnt) begin
            cur_d = pred_port;
            st_d  = ST_RESV;
          end
        end
      end
      ST_RESV: begin
        req_en = 1'b1;
        if (is_head) begin
          route_valid = 1'b1;
          if (resv_gnt) begin
            out_en = 1'b1;  // speculative traversal
            if (hit) begin
              in_ready = 1'b1;
              st_d     = is_tail ? ST_IDLE : ST_ACTIVE;
            end else begin
              kill_d = cur_vec;
              cur_d  = rc_port;
              st_d   = ST_ALLOC;
            end
          end else begin
            cur_d = rc_port;
            st_d  = ST_ALLOC;
          end
        end else if (!resv_gnt) begin
          st_d = ST_IDLE;
        end
      end
      ST_ALLOC: begin
        req_en    = 1'b1;
        resv_firm = 1'b1;
        if (resv_gnt) st_d = ST_SEND;
      end
      ST_SEND: begin
        req_en    = 1'b1;
        resv_firm = 1'b1;
        out_en    = in_valid;
        in_ready  = in_valid;
        if (in_valid) st_d = is_tail ? ST_IDLE : ST_ACTIVE;
      end
      ST_ACTIVE: begin
        req_en    = 1'b1;
        resv_firm = 1'b1;
        out_en    = in_valid;
        in_ready  = in_valid;
        if (is_tail) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      kill_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      kill_q <= kill_d;
    end
  end

  assign kill       = kill_q;
  assign out_flit   = in_flit;
  assign route_port = rc_port;

  // ---------------- assertions ----------------
  p_kill_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kill));

  p_kill_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill) |=> !(|kill));

  p_kill_after_unpopped_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill) |-> ($past(out_valid) == kill) && !$past(in_ready));

  p_kill_firm_elsewhere_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill) |-> resv_firm && ((kill & resv_req) == '0));

  p_out_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  p_pop_needs_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (|(out_valid & resv_req)));

  p_wait_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_firm && !resv_gnt && !(|out_valid) && !in_ready) |=> !(|kill) || $past(|out_valid));

  p_firm_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resv_firm |-> $onehot(resv_req));
endmodule

// File: tb/sim_spec_input_channel.sv
`timescale 1ns/1ps
module sim_spec_input_channel;
  logic        clk, rst_n;
  logic [3:0]  my_x, my_y;
  logic [15:0] in_flit;
  logic        in_valid, in_ready;
  logic [2:0]  pred_port;
  logic [4:0]  resv_req;
  logic        resv_firm, resv_gnt;
  logic [15:0] out_flit;
  logic [4:0]  out_valid, kill;
  logic        route_valid;
  logic [2:0]  route_port;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  spec_input_channel u0 (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_flit(in_flit), .in_valid(in_valid), .in_ready(in_ready),
    .pred_port(pred_port), .resv_req(resv_req), .resv_firm(resv_firm),
    .resv_gnt(resv_gnt), .out_flit(out_flit), .out_valid(out_valid),
    .kill(kill), .route_valid(route_valid), .route_port(route_port)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [4:0] oh(input int p);
    return 5'(1 << p);
  endfunction

  // type in [15:14], dest Y in [7:4], dest X in [3:0]
  function automatic logic [15:0] mk(input logic [1:0] t, input int dx, input int dy);
    return {t, 6'h15, 4'(dy), 4'(dx)};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] f, input int p, input logic g);
    @(negedge clk);
    in_valid  = v;
    in_flit   = f;
    pred_port = 3'(p);
    resv_gnt  = g;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; my_x = 4'd2; my_y = 4'd2;
    in_valid = 0; in_flit = '0; pred_port = 3'd2; resv_gnt = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "kill in reset", int'(kill), 0);
    @(negedge clk); rst_n = 1'b1;
    drive(0, '0, 2, 0);
    chk("R1", "out_valid idle", int'(out_valid), 0);
    chk("R1", "in_ready idle", int'(in_ready), 0);
    chk("R1", "req on prediction", int'(resv_req), int'(oh(2)));
    chk("R1", "tentative", int'(resv_firm), 0);
  endtask

  task automatic t_hit(input int p, input int dx, input int dy);
    drive(0, '0, p, 0);
    chk("R2", "tentative req", int'(resv_req), int'(oh(p)));
    chk("R2", "firm low", int'(resv_firm), 0);
    drive(0, '0, p, 1);
    drive(1, mk(2'b01, dx, dy), p, 1);
    chk("R4", "spec strobe", int'(out_valid), int'(oh(p)));
    chk("R4", "pop on hit", int'(in_ready), 1);
    chk("R3", "route", int'(route_port), p);
    chk("R3", "route_valid", int'(route_valid), 1);
    drive(1, mk(2'b00, 0, 0), p, 1);
    chk("R4", "no kill after hit", int'(kill), 0);
    chk("R5", "body strobe", int'(out_valid), int'(oh(p)));
    chk("R5", "body pop", int'(in_ready), 1);
    drive(1, mk(2'b10, 0, 0), p, 1);
    chk("R5", "tail strobe", int'(out_valid), int'(oh(p)));
    chk("R5", "tail pop", int'(in_ready), 1);
    drive(0, '0, 3, 0);
    chk("R10", "idle req resumes", int'(resv_req), int'(oh(3)));
    chk("R10", "idle no strobe", int'(out_valid), 0);
  endtask

  task automatic t_miss(input int p, input int dx, input int dy, input int exp, input int waitc);
    logic [15:0] h;
    h = mk(2'b01, dx, dy);
    drive(0, '0, p, 1);
    drive(1, h, p, 1);
    chk("R6", "spec strobe on guess", int'(out_valid), int'(oh(p)));
    chk("R6", "no pop on miss", int'(in_ready), 0);
    chk("R3", "route on miss", int'(route_port), exp);
    drive(1, h, p, (waitc == 0));
    chk("R6", "kill guessed port", int'(kill), int'(oh(p)));
    chk("R6", "firm req correct port", int'(resv_req), int'(oh(exp)));
    chk("R6", "firm flag", int'(resv_firm), 1);
    chk("R6", "no strobe with kill", int'(out_valid), 0);
    for (int i = 0; i < waitc; i++) begin
      drive(1, h, p, (i == waitc - 1));
      chk("R11", "wait no strobe", int'(out_valid), 0);
      chk("R11", "wait no pop", int'(in_ready), 0);
      chk("R11", "wait no kill", int'(kill), 0);
    end
    drive(1, h, p, 1);
    chk("R7", "resend strobe", int'(out_valid), int'(oh(exp)));
    chk("R7", "resend pop", int'(in_ready), 1);
    chk("R7", "kill cleared", int'(kill), 0);
    drive(1, mk(2'b10, 0, 0), p, 1);
    chk("R5", "tail after repair", int'(out_valid), int'(oh(exp)));
    drive(0, '0, p, 0);
    chk("R10", "idle after repair", int'(resv_req), int'(oh(p)));
  endtask

  task automatic t_base(input int p, input int dx, input int dy, input int exp);
    logic [15:0] h;
    h = mk(2'b11, dx, dy);
    drive(1, h, p, 1);
    chk("R8", "no strobe in route cycle", int'(out_valid), 0);
    chk("R8", "no req in route cycle", int'(resv_req), 0);
    chk("R3", "route_valid", int'(route_valid), 1);
    chk("R3", "dimension order", int'(route_port), exp);
    drive(1, h, p, 1);
    chk("R8", "firm req", int'(resv_req), int'(oh(exp)));
    chk("R8", "no kill", int'(kill), 0);
    drive(1, h, p, 1);
    chk("R8", "send strobe", int'(out_valid), int'(oh(exp)));
    chk("R8", "send pop", int'(in_ready), 1);
    chk("R8", "no kill at send", int'(kill), 0);
    drive(0, '0, p, 0);
    chk("R10", "single flit back to idle", int'(resv_req), int'(oh(p)));
    chk("R8", "no late kill", int'(kill), 0);
  endtask

  task automatic t_withdraw();
    drive(0, '0, 4, 1);
    drive(0, '0, 1, 1);
    chk("R9", "held port ignores new guess", int'(resv_req), int'(oh(4)));
    drive(0, '0, 1, 0);
    chk("R9", "still held this cycle", int'(resv_req), int'(oh(4)));
    drive(0, '0, 1, 0);
    chk("R9", "idle tracks guess", int'(resv_req), int'(oh(1)));
    chk("R9", "tentative again", int'(resv_firm), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hit(1, 5, 2);
    t_hit(4, 2, 0);
    t_miss(1, 0, 2, 2, 0);
    t_miss(3, 7, 9, 1, 2);
    t_base(0, 2, 2, 0);
    t_base(2, 6, 0, 1);
    t_base(1, 0, 7, 2);
    t_base(4, 2, 5, 3);
    t_base(3, 2, 1, 4);
    t_withdraw();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule